// File: doc/BRIEF.md
# Selectable-Order Byte Serial Port

This block moves one byte in each direction over three serial lines: a shift clock, a data output and a data input. Software first loads the transmit byte through a small register bus, then writes the control register with the start bit set. The port then shifts eight bits out and eight bits in at the same time. A mode bit chooses whether the transfer begins with the most significant bit or with the least significant bit.

The shift clock is generated in one of two ways. In internal mode the port drives the clock itself, and the clock level toggles on each pulse of the instruction-cycle strobe `cyc_tick`. In external mode the port accepts a clock from a remote master. That clock first passes through a synchronizer, and edge detection runs on the synchronized copy.

When the eighth rising edge arrives, the received byte can be read from the data register. At that point the busy indication drops, a done flag sets, and an interrupt is raised if it is enabled. The bus is plain: a write is one strobe and a read is one strobe, with no back-pressure. The bus never stalls. Accesses that arrive while a transfer is running are simply dropped.

Top module: `ser_shift_port`

## Requirements
- R1: Once reset is released, a read of the control register returns 0, `sck_o` is 1, `sd_o` is 1, `irq` is 0 and `sck_oe` is 1.
- R2: A transfer moves exactly 8 bits. After it ends, a read of the data register (address 1) returns the byte the peer sent, and the peer has received the byte that was loaded before the start.
- R3: Control bit 2 sets the bit order. When it is 1 the first bit on each line is bit 7. When it is 0 the first bit is bit 0.
- R4: `sd_o` changes only just after a falling shift-clock edge. `sd_i` is sampled on the rising edge.
- R5: Control bit 1 set to 0 selects internal clock mode. In this mode `sck_oe` is 1, SCK idles high, and SCK toggles once per `cyc_tick` pulse during a transfer. The first fall comes at the first tick after start, so SCK stays high until that tick.
- R6: Control bit 1 set to 1 selects external clock mode. In this mode `sck_oe` is 0 and the port shifts on the edges of `sck_i`, after synchronizing it.
- R7: The port is busy from start until the eighth rising edge. Busy reads as control bit 0 and done reads as control bit 7. At the eighth rising edge busy clears and done sets. Done clears when the data register is read or written, and also when a new transfer starts. Busy and done are never both set.
- R8: `irq` is 1 exactly while done is set and control bit 3 (interrupt enable) is 1.
- R9: While busy, writes to the data register and to the control register are ignored. The byte in flight and the mode bits do not change.
- R10: A transfer starts only when the control register (address 0) is written with bit 0 set while the port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | Instruction-cycle strobe; each pulse gives one shift-clock half period in internal mode |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a data read clears done) |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| sck_i | input | 1 | External shift clock |
| sck_o | output | 1 | Internally generated shift clock |
| sck_oe | output | 1 | Drive enable for sck_o (1 in internal mode) |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
Several internal faults show up at the ports within one transfer:
- A bit counter that is off by one moves the done flag and `irq` one shift-clock period early or late. It also leaves the received byte shifted by one position.
- A wrong shift direction shows as a bit-reversed byte, both at the peer and in the data register, as soon as the transfer completes.
- A synchronizer that detects the wrong edge, or a master clock that starts low, shifts data at the wrong phase. This corrupts the very first captured bit.
- Busy-gating faults change the byte the peer receives when a mid-transfer write arrives, so they show within the same transfer.

// File: rtl/ser_shift_pkg.sv
package ser_shift_pkg;
  // control register write/read bit positions (bit WIDTH-1 reads done)
  localparam int CTL_GO  = 0;  // write: start, read: busy
  localparam int CTL_EXT = 1;  // external clock select
  localparam int CTL_MSB = 2;  // most significant bit first
  localparam int CTL_IE  = 3;  // interrupt enable

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_DATA = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic ext;
    logic msb;
    logic ie;
  } mode_t;
endpackage

// File: rtl/ser_sck_gen.sv
module ser_sck_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ext,
  input  logic tick,
  input  logic sck_i,
  output logic sck_o,
  output logic sck_oe,
  output logic fall,
  output logic rise
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] sync_q;
  logic             int_q;
  logic             s_now, s_prev;

  // synchronizer plus one history flop for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[CHAIN-2:0], sck_i};
  end

  assign s_now  = sync_q[CHAIN-2];
  assign s_prev = sync_q[CHAIN-1];

  // internal clock: idles high, toggles per strobe while running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                int_q <= 1'b1;
    else if (run && !ext) begin
      if (tick)                int_q <= ~int_q;
    end else                   int_q <= 1'b1;
  end

  always_comb begin
    if (ext) begin
      fall = run &  s_prev & ~s_now;
      rise = run & ~s_prev &  s_now;
    end else begin
      fall = run & tick &  int_q;
      rise = run & tick & ~int_q;
    end
  end

  assign sck_o  = int_q;
  assign sck_oe = ~ext;
endmodule

// File: rtl/ser_shift_core.sv
module ser_shift_core #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             start,
  input  logic             fall,
  input  logic             rise,
  input  logic             msb_first,
  input  logic             sd_i,
  output logic [WIDTH-1:0] shreg,
  output logic             sd_o,
  output logic             last
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt_q <= '0;
      out_q <= 1'b1;
    end else begin
      if (load) shreg <= load_val;
      if (start) cnt_q <= '0;
      if (fall) out_q <= msb_first ? shreg[WIDTH-1] : shreg[0];
      if (rise) begin
        cnt_q <= cnt_q + 1'b1;
        if (msb_first) shreg <= {shreg[WIDTH-2:0], sd_i};
        else           shreg <= {sd_i, shreg[WIDTH-1:1]};
      end
    end
  end

  assign last = rise && (cnt_q == CW'(WIDTH - 1));
  assign sd_o = out_q;
endmodule

// File: rtl/ser_shift_port.sv
module ser_shift_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             sd_i,
  output logic             sd_o,
  output logic             irq
);
  import ser_shift_pkg::*;

  mode_t            mode_q;
  logic             busy_q, done_q;
  logic             wr_ctrl, wr_data, data_acc, start;
  logic             fall, rise, last;
  logic [WIDTH-1:0] shreg;
  logic [WIDTH-1:0] ctl_view;
  logic             unused_wdata;

  assign wr_ctrl  = bus_wr && (bus_addr == SEL_CTRL) && !busy_q;
  assign wr_data  = bus_wr && (bus_addr == SEL_DATA) && !busy_q;
  assign data_acc = (bus_wr || bus_rd) && (bus_addr == SEL_DATA);
  assign start    = wr_ctrl && bus_wdata[CTL_GO];

  assign unused_wdata = ^bus_wdata[WIDTH-1:CTL_IE+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mode_q.ext <= bus_wdata[CTL_EXT];
        mode_q.msb <= bus_wdata[CTL_MSB];
        mode_q.ie  <= bus_wdata[CTL_IE];
      end
      if (start)     busy_q <= 1'b1;
      else if (last) busy_q <= 1'b0;
      if (last)                    done_q <= 1'b1;
      else if (start || data_acc)  done_q <= 1'b0;
    end
  end

  ser_sck_gen #(.SYNC_STAGES(SYNC_STAGES)) u_sck (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy_q),
    .ext    (mode_q.ext),
    .tick   (cyc_tick),
    .sck_i  (sck_i),
    .sck_o  (sck_o),
    .sck_oe (sck_oe),
    .fall   (fall),
    .rise   (rise)
  );

  ser_shift_core #(.WIDTH(WIDTH)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_data),
    .load_val  (bus_wdata),
    .start     (start),
    .fall      (fall),
    .rise      (rise),
    .msb_first (mode_q.msb),
    .sd_i      (sd_i),
    .shreg     (shreg),
    .sd_o      (sd_o),
    .last      (last)
  );

  always_comb begin
    ctl_view          = '0;
    ctl_view[CTL_GO]  = busy_q;
    ctl_view[CTL_EXT] = mode_q.ext;
    ctl_view[CTL_MSB] = mode_q.msb;
    ctl_view[CTL_IE]  = mode_q.ie;
    ctl_view[WIDTH-1] = done_q;
  end

  assign bus_rdata = (bus_addr == SEL_DATA) ? shreg : ctl_view;
  assign irq       = done_q & mode_q.ie;
endmodule

// File: rtl/ser_shift_port_chk.sv
module ser_shift_port_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic ext,
  input logic ie,
  input logic irq,
  input logic sck_o,
  input logic sd_o
);
  // R4: the data line moves only together with a falling internal clock
  p_sdo_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sd_o) && !ext) |-> $fell(sck_o));

  // R5: clock is high when a master transfer begins
  p_first_half_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !ext) |-> sck_o);

  // R5: clock idles high in master mode
  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ext) |-> sck_o);

  // R7: end of busy always reports done
  p_end_sets_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7: busy and done exclusive
  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R8: interrupt follows a new completion when enabled
  p_irq_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && ie) |-> irq);
endmodule

bind ser_shift_port ser_shift_port_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (busy_q),
  .done  (done_q),
  .ext   (mode_q.ext),
  .ie    (mode_q.ie),
  .irq   (irq),
  .sck_o (sck_o),
  .sd_o  (sd_o)
);

// File: tb/sim_ser_shift_port.sv
module sim_ser_shift_port;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {tx byte, peer byte, msb_first, ext_clock}
  localparam logic [17:0] VEC [NVEC] = '{
    {8'hA5, 8'h3C, 1'b1, 1'b0},
    {8'h01, 8'h80, 1'b0, 1'b0},
    {8'hC4, 8'h5A, 1'b1, 1'b1},
    {8'h96, 8'h0F, 1'b0, 1'b1},
    {8'hFF, 8'h00, 1'b0, 1'b0},
    {8'h00, 8'hFF, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bench_sck = 1'b1;
  logic       sck_o, sck_oe, sd_i, sd_o, irq;

  logic tick_auto = 1'b0, tick_req = 1'b0;
  logic [7:0] peer_tx = '0, peer_cap = '0;
  logic       peer_msb = 1'b0, sd_i_drv = 1'b1;
  int         pfall = 0;
  int         nchk = 0, nerr = 0;

  wire sck_line = sck_oe ? sck_o : bench_sck;
  assign sd_i = sd_i_drv;

  ser_shift_port u0 (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_i(bench_sck), .sck_o(sck_o), .sck_oe(sck_oe),
    .sd_i(sd_i), .sd_o(sd_o), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) cyc_tick <= tick_auto ? ~cyc_tick : tick_req;

  // peer: presents its bits after falls, captures on rises
  always @(negedge sck_line) begin
    if (pfall < 8) sd_i_drv <= peer_msb ? peer_tx[7-pfall] : peer_tx[pfall];
    pfall <= pfall + 1;
  end
  always @(posedge sck_line)
    peer_cap <= peer_msb ? {peer_cap[6:0], sd_o} : {sd_o, peer_cap[7:1]};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic peer_arm(input logic [7:0] p, input logic m);
    peer_tx = p; peer_msb = m; pfall = 0; peer_cap = '0;
  endtask

  task automatic drive_ext_clock();
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); bench_sck = 1'b0;
      repeat (4) @(negedge clk);
      bench_sck = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 400 && !irq; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    tick_auto = 1'b0;
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not complete");
    finish_sim();
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] tx, pb;
    logic       m, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(1'b0, rd);
    chk(rd == 8'h00, "R1 ctrl", rd, 0);
    chk(sck_o === 1'b1 && sd_o === 1'b1, "R1 lines", {sck_o, sd_o}, 3);
    chk(irq === 1'b0 && sck_oe === 1'b1, "R1 irq/oe", {irq, sck_oe}, 1);

    // vector table: full transfers in both orders and clock modes
    for (int v = 0; v < NVEC; v++) begin
      {tx, pb, m, e} = VEC[v];
      bus_write(1'b1, tx);
      peer_arm(pb, m);
      bus_write(1'b0, {4'b0, 1'b1, m, e, 1'b1});
      chk(sck_oe === ~e, e ? "R6 oe low" : "R5 oe high", sck_oe, ~e);
      if (e) drive_ext_clock();
      else   tick_auto = 1'b1;
      wait_irq();
      chk(irq === 1'b1, "R8 irq set", irq, 1);
      bus_read(1'b0, rd);
      chk(rd[0] == 1'b0 && rd[7] == 1'b1, "R7 busy/done", rd, {1'b1, 7'b0} | {5'b0, m, e, 1'b0} | 8'h08);
      bus_read(1'b1, rd);
      chk(rd == pb, "R2 R3 received byte", rd, pb);
      chk(peer_cap == tx, "R2 R3 R4 sent byte", peer_cap, tx);
      bus_read(1'b0, rd);
      chk(rd[7] == 1'b0 && irq == 1'b0, "R7 done cleared by read", rd, 0);
    end

    // R10: control write without start bit leaves port idle
    bus_write(1'b0, 8'h04);
    repeat (4) @(negedge clk);
    bus_read(1'b0, rd);
    chk(rd[0] == 1'b0, "R10 no start", rd, 8'h04);

    // R5 first fall at first tick; R9 writes while busy ignored
    bus_write(1'b1, 8'h6B);
    peer_arm(8'h21, 1'b0);
    bus_write(1'b0, 8'h09);
    repeat (5) @(negedge clk);
    chk(sck_o === 1'b1, "R5 high before tick", sck_o, 1);
    @(negedge clk); tick_req = 1'b1;
    @(negedge clk); tick_req = 1'b0;
    #1 chk(sck_o === 1'b0, "R5 fall at first tick", sck_o, 0);
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, 8'h0C);
    bus_read(1'b0, rd);
    chk(rd[0] == 1'b1 && rd[2] == 1'b0, "R9 ctrl write ignored", rd, 8'h09);
    tick_auto = 1'b1;
    wait_irq();
    chk(peer_cap == 8'h6B, "R9 data write ignored", peer_cap, 8'h6B);

    // R7: done cleared by data write
    bus_write(1'b1, 8'h55);
    bus_read(1'b0, rd);
    chk(rd[7] == 1'b0 && irq == 1'b0, "R7 done cleared by write", rd, 8'h08);

    // R8: interrupt disabled keeps irq low while done sets
    peer_arm(8'h99, 1'b1);
    bus_write(1'b0, 8'h05);
    tick_auto = 1'b1;
    repeat (60) @(negedge clk);
    tick_auto = 1'b0;
    chk(irq === 1'b0, "R8 irq gated", irq, 0);
    bus_read(1'b0, rd);
    chk(rd[7] == 1'b1, "R8 done without irq", rd, 8'h84);

    finish_sim();
  end
endmodule